// File: doc/BRIEF.md
# Card Command and Response Unit

This unit issues one command at a time to a memory-card command engine and keeps the engine's answer for host software. The host writes a 6-bit command index and a 32-bit argument, which it supplies as two 16-bit halves. It also writes a configuration word and the block geometry. A launch strobe then presents the index and argument on a parallel request port. The card side answers in one of two ways. It can report that no response came back. Otherwise it reports a byte count and then streams that many bytes, one per cycle.

The bytes are packed into nine 16-bit response entries, and each read of the response register drains one entry. A byte at an even position goes into the low half of one entry. The byte after it goes into the high half of the following entry. All nine entries are cleared at every launch. When the command ends, the unit sets either end-of-command status and interrupt or a response-timeout status. If data transfer is enabled, it also loads the transfer byte count.

Top module: `cmd_rsp_unit`

## Requirements
- R1: A write to register address 0 keeps only bits 5:0 as the command index. A read of address 0 returns the index ORed with 0x40.
- R2: A write to address 1 replaces argument bits 31:16 and keeps bits 15:0. A write to address 2 replaces bits 15:0 and keeps bits 31:16. Reads of addresses 1 and 2 return the matching half. `req_arg` carries the full argument while `req_valid` is high.
- R3: A `cmd_go` pulse is accepted only while `clk_en` is high and no command is in flight. A rejected pulse raises no request and leaves the status register (address 6) and the response entries as they were.
- R4: An accepted launch clears status bits 1 and 13, interrupt bit 2 (interrupt register at address 8) and all nine response entries, and resets the response read index to 0.
- R5: Response byte j with j even is ORed into bits 7:0 of entry j/2. Byte j with j odd is ORed into bits 15:8 of entry (j+1)/2. A byte whose entry would be past entry 8 is dropped.
- R6: The response type is held in configuration register (address 3) bits 1:0. With type 0, no byte is stored. The command still ends with end-of-command status.
- R7: Each read of address 7 returns the entry at the read index, and the index then advances. After all nine entries have been read, further reads return 0 and the index stays put.
- R8: A response ends with status bit 13 set, interrupt bit 2 set and `irq` high. A no-response answer sets only status bit 1. Status bit 8 always shows `clk_en`.
- R9: The data-enable flag is configuration bit 2. When it is set and a response arrives, `xfer_bytes` becomes the block count (address 5) times the block length (address 4, bits 11:0). Otherwise `xfer_bytes` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drains entries at address 7) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| clk_en | input | 1 | Card clock running; launches gated on it |
| cmd_go | input | 1 | Launch strobe |
| req_valid | output | 1 | Request presented to card engine |
| req_idx | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| rsp_ack | input | 1 | Card engine answer valid |
| rsp_none | input | 1 | With rsp_ack: no response came back |
| rsp_len | input | 5 | With rsp_ack: response byte count |
| rsp_byte_vld | input | 1 | Response byte valid |
| rsp_byte | input | 8 | Response byte |
| irq | output | 1 | End-of-command interrupt |
| xfer_bytes | output | 28 | Transfer byte count |

## Verification
Register writes and the launch take effect at the first clock edge, so the bench reads them back at the next falling edge. `req_valid` is high one cycle after the accepted `cmd_go`. Status, interrupt and `xfer_bytes` change on the edge that takes the acknowledge (for a zero-length or no-response answer) or the last byte, and the bench samples them half a cycle later. Response reads are combinational, so each one is checked before the edge that advances the index.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int IDX_W     = 6;
    localparam int ARG_W     = 32;
    localparam int HALF_W    = 16;
    localparam int N_ENTRY   = 9;
    localparam int LEN_W     = 5;
    localparam int BLKLEN_W  = 12;
    localparam int NBLK_W    = 16;
    localparam int XFER_W    = BLKLEN_W + NBLK_W;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
    localparam logic [ADDR_W-1:0] A_ARGH   = 4'd1;
    localparam logic [ADDR_W-1:0] A_ARGL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CFG    = 4'd3;
    localparam logic [ADDR_W-1:0] A_BLKLEN = 4'd4;
    localparam logic [ADDR_W-1:0] A_NBLK   = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;
    localparam logic [ADDR_W-1:0] A_RESP   = 4'd7;
    localparam logic [ADDR_W-1:0] A_INT    = 4'd8;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_STREAM
    } seq_state_e;
endpackage

// File: rtl/ccr_regs.sv
module ccr_regs
    import ccr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [HALF_W-1:0]   wdata,
    output logic [IDX_W-1:0]    cmd_idx,
    output logic [ARG_W-1:0]    arg,
    output logic [1:0]          rsp_type,
    output logic                data_en,
    output logic [BLKLEN_W-1:0] blk_len,
    output logic [NBLK_W-1:0]   num_blk
);
    typedef struct packed {
        logic [IDX_W-1:0]    idx;
        logic [ARG_W-1:0]    arg;
        logic [1:0]          rtype;
        logic                den;
        logic [BLKLEN_W-1:0] blen;
        logic [NBLK_W-1:0]   nblk;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                A_CMD:    r_d.idx = wdata[IDX_W-1:0];
                A_ARGH:   r_d.arg[ARG_W-1:HALF_W] = wdata;
                A_ARGL:   r_d.arg[HALF_W-1:0] = wdata;
                A_CFG:    begin r_d.rtype = wdata[1:0]; r_d.den = wdata[2]; end
                A_BLKLEN: r_d.blen = wdata[BLKLEN_W-1:0];
                A_NBLK:   r_d.nblk = wdata[NBLK_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_idx  = r_q.idx;
    assign arg      = r_q.arg;
    assign rsp_type = r_q.rtype;
    assign data_en  = r_q.den;
    assign blk_len  = r_q.blen;
    assign num_blk  = r_q.nblk;

    AST_ARG_HALF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_ARGH) |=> $stable(r_q.arg[HALF_W-1:0])); // R2
endmodule

// File: rtl/ccr_rsp_store.sv
module ccr_rsp_store #(
    parameter int ENTRIES = 9,
    parameter int W       = 16,
    parameter int POS_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_pos,
    input  logic [7:0]       wr_byte,
    input  logic             pop,
    output logic [W-1:0]     rd_data
);
    localparam int RI_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic [ENTRIES-1:0][W-1:0] mem;
        logic [RI_W-1:0]           ridx;
    } store_t;

    store_t s_d, s_q;

    logic [POS_W-1:0]   target;
    logic [ENTRIES-1:0] hit_lo, hit_hi;

    assign target = POS_W'(wr_pos[POS_W-1:1]) + POS_W'(wr_pos[0]);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_hit
        assign hit_lo[e] = wr_en && !wr_pos[0] && (target == POS_W'(e));
        assign hit_hi[e] = wr_en &&  wr_pos[0] && (target == POS_W'(e));
    end

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (hit_lo[e]) s_d.mem[e][7:0]  = s_q.mem[e][7:0]  | wr_byte;
                if (hit_hi[e]) s_d.mem[e][15:8] = s_q.mem[e][15:8] | wr_byte;
            end
            if (pop && s_q.ridx < RI_W'(ENTRIES)) s_d.ridx = s_q.ridx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < ENTRIES; e++)
            if (s_q.ridx == RI_W'(e)) rd_data = s_q.mem[e];
    end

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.ridx == '0 && s_q.mem == '0)); // R4
    AST_INDEX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && s_q.ridx == RI_W'(ENTRIES)) |=> (s_q.ridx == RI_W'(ENTRIES))); // R7
endmodule

// File: rtl/ccr_seq.sv
module ccr_seq
    import ccr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                clk_en,
    input  logic                rsp_ack,
    input  logic                rsp_none,
    input  logic [LEN_W-1:0]    rsp_len,
    input  logic                rsp_byte_vld,
    input  logic [1:0]          rsp_type,
    input  logic                data_en,
    input  logic [BLKLEN_W-1:0] blk_len,
    input  logic [NBLK_W-1:0]   num_blk,
    output logic                req_valid,
    output logic                st_end,
    output logic                st_tout,
    output logic                int_end,
    output logic [XFER_W-1:0]   xfer_bytes,
    output logic                store_clr,
    output logic                store_wr,
    output logic [LEN_W-1:0]    store_pos
);
    typedef struct packed {
        seq_state_e         st;
        logic               cap;
        logic               den;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   cnt;
        logic               st_end;
        logic               st_tout;
        logic               int_end;
        logic [XFER_W-1:0]  xfer;
    } seq_t;

    seq_t q_d, q_q;
    logic launch, finish;

    assign launch = go && clk_en && (q_q.st == SQ_IDLE);

    always_comb begin
        q_d    = q_q;
        finish = 1'b0;
        case (q_q.st)
            SQ_IDLE: if (launch) begin
                q_d.st      = SQ_WAIT;
                q_d.cap     = (rsp_type != 2'd0);
                q_d.den     = data_en;
                q_d.cnt     = '0;
                q_d.st_end  = 1'b0;
                q_d.st_tout = 1'b0;
                q_d.int_end = 1'b0;
            end
            SQ_WAIT: if (rsp_ack) begin
                if (rsp_none) begin
                    q_d.st      = SQ_IDLE;
                    q_d.st_tout = 1'b1;
                end else if (rsp_len == '0) begin
                    finish = 1'b1;
                end else begin
                    q_d.st  = SQ_STREAM;
                    q_d.len = rsp_len;
                end
            end
            SQ_STREAM: if (rsp_byte_vld) begin
                q_d.cnt = q_q.cnt + 1'b1;
                if (q_q.cnt + 1'b1 == q_q.len) finish = 1'b1;
            end
            default: q_d.st = SQ_IDLE;
        endcase
        if (finish) begin
            q_d.st      = SQ_IDLE;
            q_d.st_end  = 1'b1;
            q_d.int_end = 1'b1;
            if (q_q.den) q_d.xfer = XFER_W'(num_blk) * XFER_W'(blk_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: SQ_IDLE, default: '0};
        else        q_q <= q_d;
    end

    assign req_valid  = (q_q.st == SQ_WAIT);
    assign st_end     = q_q.st_end;
    assign st_tout    = q_q.st_tout;
    assign int_end    = q_q.int_end;
    assign xfer_bytes = q_q.xfer;
    assign store_clr  = launch;
    assign store_wr   = (q_q.st == SQ_STREAM) && rsp_byte_vld && q_q.cap;
    assign store_pos  = q_q.cnt;

    AST_END_TOUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_q.st_end && q_q.st_tout)); // R8
endmodule

// File: rtl/cmd_rsp_unit.sv
module cmd_rsp_unit
    import ccr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        clk_en,
    input  logic        cmd_go,
    output logic        req_valid,
    output logic [5:0]  req_idx,
    output logic [31:0] req_arg,
    input  logic        rsp_ack,
    input  logic        rsp_none,
    input  logic [4:0]  rsp_len,
    input  logic        rsp_byte_vld,
    input  logic [7:0]  rsp_byte,
    output logic        irq,
    output logic [27:0] xfer_bytes
);
    logic [IDX_W-1:0]    cmd_idx;
    logic [ARG_W-1:0]    arg;
    logic [1:0]          rsp_type;
    logic                data_en;
    logic [BLKLEN_W-1:0] blk_len;
    logic [NBLK_W-1:0]   num_blk;
    logic                st_end, st_tout, int_end;
    logic                store_clr, store_wr;
    logic [LEN_W-1:0]    store_pos;
    logic [HALF_W-1:0]   rsp_word;

    ccr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cmd_idx(cmd_idx), .arg(arg), .rsp_type(rsp_type), .data_en(data_en),
        .blk_len(blk_len), .num_blk(num_blk)
    );

    ccr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(cmd_go), .clk_en(clk_en),
        .rsp_ack(rsp_ack), .rsp_none(rsp_none), .rsp_len(rsp_len),
        .rsp_byte_vld(rsp_byte_vld), .rsp_type(rsp_type), .data_en(data_en),
        .blk_len(blk_len), .num_blk(num_blk), .req_valid(req_valid),
        .st_end(st_end), .st_tout(st_tout), .int_end(int_end),
        .xfer_bytes(xfer_bytes), .store_clr(store_clr), .store_wr(store_wr),
        .store_pos(store_pos)
    );

    ccr_rsp_store #(.ENTRIES(N_ENTRY), .W(HALF_W), .POS_W(LEN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(store_clr), .wr_en(store_wr),
        .wr_pos(store_pos), .wr_byte(rsp_byte),
        .pop(reg_rd && reg_addr == A_RESP), .rd_data(rsp_word)
    );

    assign req_idx = cmd_idx;
    assign req_arg = arg;
    assign irq     = int_end;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CMD:    reg_rdata = HALF_W'(cmd_idx) | 16'h0040;
            A_ARGH:   reg_rdata = arg[ARG_W-1:HALF_W];
            A_ARGL:   reg_rdata = arg[HALF_W-1:0];
            A_CFG:    reg_rdata = {13'd0, data_en, rsp_type};
            A_BLKLEN: reg_rdata = HALF_W'(blk_len);
            A_NBLK:   reg_rdata = num_blk;
            A_STAT:   reg_rdata = {2'b00, st_end, 4'd0, clk_en, 6'd0, st_tout, 1'b0};
            A_RESP:   reg_rdata = rsp_word;
            A_INT:    reg_rdata = {13'd0, int_end, 2'b00};
            default:  reg_rdata = '0;
        endcase
    end

    AST_LAUNCH_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(clk_en)); // R3
endmodule

// File: tb/test_cmd_rsp_unit.sv
module test_cmd_rsp_unit;
    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic        clk_en = 0, cmd_go = 0;
    logic        req_valid;
    logic [5:0]  req_idx;
    logic [31:0] req_arg;
    logic        rsp_ack = 0, rsp_none = 0, rsp_byte_vld = 0;
    logic [4:0]  rsp_len = 0;
    logic [7:0]  rsp_byte = 0;
    logic        irq;
    logic [27:0] xfer_bytes;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0]  bytes [20];
    logic [15:0] exp_e [9];
    logic [27:0] exp_xfer = 0;

    always #2.5 clk = ~clk;

    cmd_rsp_unit i_cmd_rsp_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    function automatic void pack(input int len, input logic [1:0] rtype);
        for (int e = 0; e < 9; e++) exp_e[e] = 16'h0;
        if (rtype != 0)
            for (int j = 0; j < len; j++) begin
                int e = (j >> 1) + (j & 1);
                if (e < 9) begin
                    if (j % 2 == 0) exp_e[e][7:0]  = exp_e[e][7:0]  | bytes[j];
                    else            exp_e[e][15:8] = exp_e[e][15:8] | bytes[j];
                end
            end
    endfunction

    // one full command; starts and ends at a falling edge
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] a, input logic [1:0] rtype,
                           input logic den, input logic [11:0] blen, input logic [15:0] nblk,
                           input bit none, input int len);
        logic [15:0] v;
        wr(4'd0, {10'h3ff, idx});
        wr(4'd1, a[31:16]);
        wr(4'd2, a[15:0]);
        wr(4'd3, {13'd0, den, rtype});
        wr(4'd4, {4'hf, blen});
        wr(4'd5, nblk);
        rd(4'd0, v);       chk("R1 cmd readback", v, {10'd0, idx} | 16'h40);
        rd(4'd1, v);       chk("R2 arg high", v, a[31:16]);
        cmd_go = 1;
        @(negedge clk);
        cmd_go = 0;
        chk("R3 request raised", req_valid, 1);
        chk("R2 request arg", req_arg, a);
        chk("R1 request idx", req_idx, idx);
        rd(4'd8, v);       chk("R4 interrupt cleared", v, 0);
        rsp_ack = 1; rsp_none = none; rsp_len = 5'(len);
        @(negedge clk);
        rsp_ack = 0; rsp_none = 0;
        if (!none)
            for (int j = 0; j < len; j++) begin
                rsp_byte_vld = 1; rsp_byte = bytes[j];
                @(negedge clk);
            end
        rsp_byte_vld = 0;
        if (!none && den) exp_xfer = 28'(nblk) * 28'(blen);
        rd(4'd6, v);
        chk("R8 status", v, none ? 16'h0102 : 16'h2100);
        chk("R8 irq", irq, !none);
        chk("R9 transfer count", xfer_bytes, exp_xfer);
        pack(none ? 0 : len, rtype);
        for (int e = 0; e < 9; e++) begin
            rd(4'd7, v);
            chk(rtype == 0 ? "R6 no capture" : "R5 entry", v, exp_e[e]);
        end
        rd(4'd7, v); chk("R7 drained zero", v, 0);
        rd(4'd7, v); chk("R7 drained zero again", v, 0);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset req_valid", req_valid, 0);
        chk("reset irq", irq, 0);
        rd(4'd6, v); chk("R8 reset status", v, 0);
        rd(4'd7, v); chk("R7 reset entry", v, 0);

        // R2: halves keep each other
        wr(4'd1, 16'hdead); wr(4'd2, 16'hbeef); wr(4'd1, 16'h1234);
        rd(4'd2, v); chk("R2 low kept", v, 16'hbeef);
        rd(4'd1, v); chk("R2 high replaced", v, 16'h1234);

        // R3: launch ignored with clock off
        cmd_go = 1; @(negedge clk); cmd_go = 0;
        chk("R3 no request clk off", req_valid, 0);
        rd(4'd6, v); chk("R3 status unchanged", v, 0);

        clk_en = 1;
        // directed: 17 bytes fill all nine entries, 18th byte dropped
        for (int j = 0; j < 20; j++) bytes[j] = 8'(j * 17 + 3);
        run_cmd(6'd17, 32'hcafe0001, 2'd1, 1'b1, 12'd512, 16'd3, 0, 20);
        // directed: odd length, zero length, timeout, type 0
        run_cmd(6'd2, 32'h0, 2'd2, 1'b0, 12'd1, 16'd1, 0, 5);
        run_cmd(6'd0, 32'h1, 2'd1, 1'b1, 12'd8, 16'd2, 0, 0);
        run_cmd(6'd55, 32'h5, 2'd1, 1'b1, 12'd99, 16'd99, 1, 0);
        run_cmd(6'd9, 32'h7, 2'd0, 1'b0, 12'd4, 16'd4, 0, 6);

        // R3: clock off after a good command, stored state survives rejected launch
        clk_en = 0;
        cmd_go = 1; @(negedge clk); cmd_go = 0;
        chk("R3 no request", req_valid, 0);
        rd(4'd6, v); chk("R3 status kept", v, 16'h2000);
        chk("R3 irq kept", irq, 1);
        clk_en = 1;

        for (int n = 0; n < 30; n++) begin
            for (int j = 0; j < 20; j++) bytes[j] = 8'($urandom);
            run_cmd(6'($urandom), $urandom, 2'($urandom), 1'($urandom),
                    12'($urandom), 16'($urandom), ($urandom % 5) == 0, $urandom % 21);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule